// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block holds the coherence state of one line in a write-back, write-allocate cache attached to a shared snooping bus. Each cycle it may receive a request from the local processor (read or write) and a snooped miss from another cache on the bus (read or write). From these it computes the line's next state among four stable states: Invalid, Shared, Exclusive and Modified. It also raises a bus request, a flag saying this cache drives the line's data onto the bus, and a flag saying memory must take a copy of dirty data.

A processor access to a valid line is a hit. An access to an Invalid line is a miss. A read miss uses the bus-shared response, sampled in the same cycle, to choose between a clean private copy and a shared copy. When a snoop and a processor request arrive together, the snoop is applied first. The processor request is then evaluated against the state the snoop left, so a hit on a line the snoop invalidated is handled as a miss.

All results are registered. The state and the three flags for an event presented before a rising edge appear just after that edge. The tag comparison, the data array, bus arbitration and transient states live outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `line_state` is Invalid, `bus_cmd` is none, and `supply_data` and `write_back` are 0. The state encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: A processor read to an Invalid line issues `bus_cmd`=01 (read). The line becomes Exclusive if `bus_shared` is 0 and Shared if `bus_shared` is 1.
- R3: A processor write to an Invalid line issues `bus_cmd`=10 (read-exclusive) and the line becomes Modified.
- R4: A processor write to an Exclusive line makes it Modified with `bus_cmd`=00 (none).
- R5: A processor write to a Shared line makes it Modified with `bus_cmd`=11 (invalidate).
- R6: Processor reads to Shared, Exclusive or Modified lines, and writes to Modified lines, leave the state unchanged with `bus_cmd`=00.
- R7: A snooped read miss moves Exclusive or Modified to Shared with `supply_data`=1. In Shared it keeps Shared with `supply_data`=0. In Invalid it has no effect.
- R8: A snooped write miss moves Shared, Exclusive or Modified to Invalid. `supply_data` is 1 only when the line was Exclusive or Modified. In Invalid it has no effect.
- R9: `write_back` is 1 for exactly one cycle, and only when a Modified line snoops a read or write miss. `supply_data` is also 1 in that cycle.
- R10: When a snoop and a processor request arrive together, the snoop transition and its flags are applied first. The processor request is then applied to the resulting state, and its bus command is issued from that state.
- R11: With no request of either kind, the state holds and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access valid this cycle |
| cpu_wr | input | 1 | Processor access is a write (1) or read (0) |
| snp_req | input | 1 | Snooped bus miss for this line this cycle |
| snp_wr | input | 1 | Snooped miss is a write miss (1) or read miss (0) |
| bus_shared | input | 1 | Another cache holds the line (for a read miss this cycle) |
| line_state | output | 2 | Registered line state |
| bus_cmd | output | 2 | Registered bus request: 00 none, 01 read, 10 read-exclusive, 11 invalidate |
| supply_data | output | 1 | Registered: this cache drives the line's data for the snooped miss |
| write_back | output | 1 | Registered: memory must capture the dirty data being supplied |

## Verification
Every result is due one rising edge after its stimulus. The bench drives inputs on a falling edge and samples all four outputs on the next falling edge, then returns the inputs to idle so that one later edge checks that the flags drop and the state holds. It reaches each of the four starting states through the block's own ports. From each one it sweeps all 32 combinations of the five request inputs, and compares the outputs against a bench model that applies the snoop first and the processor request second.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_INV  = 2'b11
  } bus_cmd_e;

endpackage

// File: rtl/mesi_snoop_step.sv
module mesi_snoop_step
  import mesi_pkg::*;
(
  input  line_st_e cur_st,
  input  logic     snp_req,
  input  logic     snp_wr,
  output line_st_e post_st,
  output logic     supply,
  output logic     wback
);

  always_comb begin
    post_st = cur_st;
    supply  = 1'b0;
    wback   = 1'b0;
    if (snp_req && (cur_st != ST_INV)) begin
      // Only an owner of a private copy drives data; dirty data also goes to memory
      supply  = (cur_st == ST_EXC) || (cur_st == ST_MOD);
      wback   = (cur_st == ST_MOD);
      post_st = snp_wr ? ST_INV : ST_SHR;
    end
  end

endmodule

// File: rtl/mesi_cpu_step.sv
module mesi_cpu_step
  import mesi_pkg::*;
(
  input  line_st_e cur_st,
  input  logic     cpu_req,
  input  logic     cpu_wr,
  input  logic     peer_shared,
  output line_st_e nxt_st,
  output bus_cmd_e cmd
);

  always_comb begin
    nxt_st = cur_st;
    cmd    = CMD_NONE;
    if (cpu_req) begin
      unique case (cur_st)
        ST_INV: begin
          if (cpu_wr) begin
            nxt_st = ST_MOD;
            cmd    = CMD_RDX;
          end else begin
            nxt_st = peer_shared ? ST_SHR : ST_EXC;
            cmd    = CMD_RD;
          end
        end
        ST_SHR: begin
          if (cpu_wr) begin
            nxt_st = ST_MOD;
            cmd    = CMD_INV;
          end
        end
        ST_EXC: begin
          if (cpu_wr) nxt_st = ST_MOD;
        end
        ST_MOD: begin
          nxt_st = ST_MOD;
        end
        default: begin
          nxt_st = ST_INV;
        end
      endcase
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_wr,
  input  logic       snp_req,
  input  logic       snp_wr,
  input  logic       bus_shared,
  output logic [1:0] line_state,
  output logic [1:0] bus_cmd,
  output logic       supply_data,
  output logic       write_back
);

  // Reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  line_st_e state_q;
  line_st_e snoop_st;
  line_st_e proc_st;
  bus_cmd_e cmd_d;
  bus_cmd_e cmd_q;
  logic     supply_d;
  logic     supply_q;
  logic     wback_d;
  logic     wback_q;
  logic     state_en;

  // Snoop first, then the processor request on what the snoop left
  mesi_snoop_step u_snoop (
    .cur_st  (state_q),
    .snp_req (snp_req),
    .snp_wr  (snp_wr),
    .post_st (snoop_st),
    .supply  (supply_d),
    .wback   (wback_d)
  );

  mesi_cpu_step u_cpu (
    .cur_st      (snoop_st),
    .cpu_req     (cpu_req),
    .cpu_wr      (cpu_wr),
    .peer_shared (bus_shared),
    .nxt_st      (proc_st),
    .cmd         (cmd_d)
  );

  assign state_en = cpu_req | snp_req;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_INV;
    end else if (state_en) begin
      state_q <= proc_st;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q    <= CMD_NONE;
      supply_q <= 1'b0;
      wback_q  <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      supply_q <= supply_d;
      wback_q  <= wback_d;
    end
  end

  assign line_state  = state_q;
  assign bus_cmd     = cmd_q;
  assign supply_data = supply_q;
  assign write_back  = wback_q;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_wr,
  input logic       snp_req,
  input logic       snp_wr,
  input logic       bus_shared,
  input logic [1:0] line_state,
  input logic [1:0] bus_cmd,
  input logic       supply_data,
  input logic       write_back
);

  // R2
  rd_miss_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 2'b00 && cpu_req && !cpu_wr && !snp_req) |=>
      (bus_cmd == 2'b01 && line_state == ($past(bus_shared) ? 2'b01 : 2'b10)));

  // R4
  excl_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 2'b10 && cpu_req && cpu_wr && !snp_req) |=>
      (line_state == 2'b11 && bus_cmd == 2'b00));

  // R5
  shared_write_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 2'b01 && cpu_req && cpu_wr && !snp_req) |=>
      (line_state == 2'b11 && bus_cmd == 2'b11));

  // R8
  snoop_wr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && snp_wr) |=> (line_state == 2'b00 || bus_cmd != 2'b00));

  // R9
  wback_from_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_back |-> ($past(line_state) == 2'b11 && supply_data));

  // R9
  wback_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_back && line_state != 2'b11) |=> !write_back);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !snp_req) |=>
      ($stable(line_state) && bus_cmd == 2'b00 && !supply_data && !write_back));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_req     (cpu_req),
  .cpu_wr      (cpu_wr),
  .snp_req     (snp_req),
  .snp_wr      (snp_wr),
  .bus_shared  (bus_shared),
  .line_state  (line_state),
  .bus_cmd     (bus_cmd),
  .supply_data (supply_data),
  .write_back  (write_back)
);

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic       cpu_req, cpu_wr, snp_req, snp_wr, bus_shared;
  logic [1:0] line_state;
  logic [1:0] bus_cmd;
  logic       supply_data, write_back;

  int errors = 0;
  int checks = 0;

  logic [1:0] got_st, got_cmd;
  logic       got_sup, got_wb;

  mesi_line_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .snp_req(snp_req), .snp_wr(snp_wr), .bus_shared(bus_shared),
    .line_state(line_state), .bus_cmd(bus_cmd),
    .supply_data(supply_data), .write_back(write_back)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One event: drive on a falling edge, capture one edge later, return to idle
  task automatic apply(input logic cr, input logic cw, input logic sr,
                       input logic sw, input logic sh);
    @(negedge clk);
    cpu_req = cr; cpu_wr = cw; snp_req = sr; snp_wr = sw; bus_shared = sh;
    @(negedge clk);
    got_st = line_state; got_cmd = bus_cmd; got_sup = supply_data; got_wb = write_back;
    cpu_req = 0; cpu_wr = 0; snp_req = 0; snp_wr = 0; bus_shared = 0;
  endtask

  // Bring the line to a given state through the ports: 0=I 1=S 2=E 3=M
  task automatic goto_state(input logic [1:0] s);
    apply(0, 0, 1, 1, 0);
    case (s)
      2'd1: apply(1, 0, 0, 0, 1);
      2'd2: apply(1, 0, 0, 0, 0);
      2'd3: apply(1, 1, 0, 0, 0);
      default: ;
    endcase
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    cpu_req = 0; cpu_wr = 0; snp_req = 0; snp_wr = 0; bus_shared = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "state in reset", line_state, 0);
    chk("R1", "cmd in reset", bus_cmd, 0);
    chk("R1", "flags in reset", {supply_data, write_back}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "state after release", line_state, 0);
    chk("R1", "flags after release", {bus_cmd, supply_data, write_back}, 0);

    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 32; v++) begin
        logic cr, cw, sr, sw, sh;
        int   mid, e_st, e_cmd, e_sup, e_wb;
        string tag;
        cr = v[0]; cw = v[1]; sr = v[2]; sw = v[3]; sh = v[4];
        goto_state(s[1:0]);
        chk("R11", "start state", line_state, s);
        // Bench model: snoop step
        mid = s; e_sup = 0; e_wb = 0;
        if (sr && s != 0) begin
          e_sup = (s >= 2) ? 1 : 0;
          e_wb  = (s == 3) ? 1 : 0;
          mid   = sw ? 0 : 1;
        end
        // Bench model: processor step on post-snoop state
        e_st = mid; e_cmd = 0;
        if (cr) begin
          if (mid == 0) begin
            e_cmd = cw ? 2 : 1;
            e_st  = cw ? 3 : (sh ? 1 : 2);
          end else if (cw) begin
            e_st  = 3;
            e_cmd = (mid == 1) ? 3 : 0;
          end
        end
        if (cr && sr)      tag = "R10";
        else if (sr)       tag = sw ? "R8" : "R7";
        else if (cr) begin
          if (s == 0)              tag = cw ? "R3" : "R2";
          else if (cw && s == 2)   tag = "R4";
          else if (cw && s == 1)   tag = "R5";
          else                     tag = "R6";
        end else           tag = "R11";
        apply(cr, cw, sr, sw, sh);
        chk(tag, $sformatf("state s=%0d v=%0d", s, v), got_st, e_st);
        chk(tag, $sformatf("cmd s=%0d v=%0d", s, v), got_cmd, e_cmd);
        chk(tag, $sformatf("supply s=%0d v=%0d", s, v), got_sup, e_sup);
        chk("R9", $sformatf("write_back s=%0d v=%0d", s, v), got_wb, e_wb);
        // Idle cycle: flags drop, state holds
        apply(0, 0, 0, 0, 0);
        chk("R11", "idle state hold", got_st, e_st);
        chk("R9", "write_back one cycle", got_wb, 0);
        chk("R11", "idle flags", {got_cmd, got_sup}, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule